// File: doc/BRIEF.md
# Flash Write State Machine

This block is the sequencing engine behind a block-erase flash array. A command decoder hands it one-cycle requests: program a page, erase a block, set a block's lock bit, suspend, resume, clear status, sleep and wake. The block runs each write job as rounds of a pulse phase and a verify phase, each lasting a programmable number of cycles. A verify-fail input, sampled on the last verify cycle, lets the surroundings inject failing verifies. Failing rounds are retried up to a parameterised limit, after which the job ends with an error.

The block keeps an 8-bit status byte and a ready/busy output. It also holds one lock bit per block, decoded from a 19-bit word address using a bottom-boot map. A protect-pin input, a two-bit reset-level input and the lock bits together decide whether a job may touch a block. Pulling the reset level low aborts everything and returns the status byte to its idle value. A sleep request is held until the running job ends.

Top module: `flash_wsm`

## Requirements
- R1: After synchronous reset `status` is 0x80, `ry_by` is 1, `asleep` is 0 and every bit of `lock_bits` is 1 (unlocked).
- R2: Status layout is bit7 ready (1) / busy (0), bit6 suspended, bit5 erase error, bit4 program error, bit3 over-program, bits 2..0 zero. `ry_by` equals bit7 and is 0 exactly while a job runs. A job accepted on edge E with a passing first verify is busy after E and ready after edge E+PULSE_CYC+VERIFY_CYC.
- R3: Request codes on `req_op` are 0 wake, 1 program, 2 erase, 3 lock, 4 suspend, 5 resume, 6 clear status, 7 sleep. A failing verify starts another full round. Bit3 is set when `ovp_in` is 1 at the passing verify of a program job.
- R4: After MAX_TRIES failing rounds the job ends with bit7 set, and with bit5 set for an erase or bit4 set for a program or lock job.
- R5: Bits 5, 4 and 3 are cleared only by the clear-status request or by power-down. If an error is set on the same edge that a clear-status request is accepted, the error bit ends up set.
- R6: `pd_level` codes are 00 power-down, 01 and 11 normal, 10 high-voltage. With `wp` = 0, a normal level and a lock bit of 0, a program, erase or lock job is rejected without going busy. The rejection sets bit5 for an erase and bit4 otherwise, and leaves `lock_bits` unchanged.
- R7: With `wp` = 1 or level 10, jobs proceed regardless of lock bits. A successful erase accepted under that override sets the block's lock bit to 1.
- R8: A successful lock job clears the addressed block's lock bit to 0.
- R9: Suspend during a program or erase stops it and sets bit6 and bit7 on the next cycle. Resume clears bit6 and restarts the interrupted round from its pulse phase, ending PULSE_CYC+VERIFY_CYC edges later.
- R10: Sleep while idle sets `asleep` on the next cycle. Sleep while a job runs takes effect on the edge the job ends. Wake leaves sleep. Job requests are ignored while asleep.
- R11: While `pd_level` is 00 any job is aborted, requests are ignored and `status` reads 0x80 from the next cycle. Lock bits are kept.
- R12: Word addresses below 0x02000 map to block 0, 0x02000..0x02FFF to block 1, 0x03000..0x03FFF to block 2, 0x04000..0x07FFF to block 3, and above that to block 3 + addr[18:15] (blocks 4..18). Bit n of `lock_bits` belongs to block n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_op | input | 3 | Request code |
| req_addr | input | 19 | Word address selecting the block |
| wp | input | 1 | Protect pin, 1 overrides lock bits |
| pd_level | input | 2 | Reset level: power-down, normal or high-voltage |
| vfy_fail | input | 1 | Injected verify failure, sampled on the last verify cycle |
| ovp_in | input | 1 | Over-program indication, sampled at a passing program verify |
| status | output | 8 | Status byte |
| ry_by | output | 1 | 1 ready, 0 busy |
| asleep | output | 1 | Sleep state |
| lock_bits | output | 19 | Per-block lock bits, 0 locked |

## Verification
Two functions can land on one edge: a clear-status request and the last failing verify that sets an error bit. A sleep request can also coincide with the end of a job. The bench counts the cycles of a job with exhausted retries and places the clear-status strobe on exactly that final edge. It then expects the program error bit still set. Separately, it issues sleep during a job and expects `asleep` to stay low up to the last busy cycle and rise together with ready.

// File: rtl/flash_wsm_pkg.sv
package flash_wsm_pkg;
    localparam int ADDR_W = 19;
    localparam int NBLK   = 19;
    localparam int BLK_W  = $clog2(NBLK);

    typedef enum logic [2:0] {
        OP_WAKE   = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_LOCK   = 3'd3,
        OP_SUSP   = 3'd4,
        OP_RESUME = 3'd5,
        OP_CLR    = 3'd6,
        OP_SLEEP  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        PD_OFF  = 2'b00,
        PD_NORM = 2'b01,
        PD_HV   = 2'b10,
        PD_ALT  = 2'b11
    } pd_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PULSE, ST_VERIFY, ST_SUSP, ST_SLEEP
    } st_e;

    typedef enum logic [1:0] {
        JOB_PROG, JOB_ERASE, JOB_LOCK
    } job_e;

    typedef struct packed {
        logic susp;
        logic err_erase;
        logic err_prog;
        logic ovp;
    } flags_t;

    typedef struct packed {
        job_e             kind;
        logic [BLK_W-1:0] blk;
        logic             ovr;
    } job_t;

    // Bottom-boot word map: small blocks at the low end, 32K blocks above.
    function automatic logic [BLK_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
        if (a < ADDR_W'(32'h02000))      return BLK_W'(0);
        else if (a < ADDR_W'(32'h03000)) return BLK_W'(1);
        else if (a < ADDR_W'(32'h04000)) return BLK_W'(2);
        else if (a < ADDR_W'(32'h08000)) return BLK_W'(3);
        else return BLK_W'(5'd3 + {1'b0, a[ADDR_W-1:15]});
    endfunction

    function automatic logic [7:0] pack_status(input logic busy, input flags_t f);
        return {~busy, f.susp, f.err_erase, f.err_prog, f.ovp, 3'b000};
    endfunction
endpackage

// File: rtl/wsm_blk_guard.sv
module wsm_blk_guard
    import flash_wsm_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBLK-1:0]   locks,
    input  logic              wp,
    input  logic [1:0]        pd,
    output logic [BLK_W-1:0]  blk,
    output logic              ovr,
    output logic              deny
);
    always_comb begin
        blk  = blk_of(addr);
        ovr  = wp || (pd == PD_HV);
        deny = !ovr && (locks[blk] == 1'b0);
    end
endmodule

// File: rtl/wsm_step_timer.sv
module wsm_step_timer #(
    parameter int PULSE_CYC  = 4,
    parameter int VERIFY_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic phase,
    output logic last
);
    localparam int MAXC = (PULSE_CYC > VERIFY_CYC) ? PULSE_CYC : VERIFY_CYC;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

    logic [CW-1:0] cnt;

    always_comb begin
        last = run && (cnt == (phase ? CW'(VERIFY_CYC - 1) : CW'(PULSE_CYC - 1)));
    end

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (last)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/flash_wsm.sv
module flash_wsm
    import flash_wsm_pkg::*;
#(
    parameter int PULSE_CYC  = 4,
    parameter int VERIFY_CYC = 2,
    parameter int MAX_TRIES  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wp,
    input  logic [1:0]        pd_level,
    input  logic              vfy_fail,
    input  logic              ovp_in,
    output logic [7:0]        status,
    output logic              ry_by,
    output logic              asleep,
    output logic [NBLK-1:0]   lock_bits
);
    localparam int TW = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;

    st_e             st;
    job_t            job;
    flags_t          flags;
    logic [TW-1:0]   tries;
    logic            sleep_pend;
    logic [NBLK-1:0] lk, lk_nxt;

    op_e              op;
    job_e             req_kind;
    logic             pd_off, busy, tm_last, sleep_req, is_job;
    logic             acc_susp, vfy_end, vfy_pass, vfy_giveup;
    logic             g_deny, g_ovr;
    logic [BLK_W-1:0] g_blk;

    always_comb begin
        op         = op_e'(req_op);
        pd_off     = (pd_level == PD_OFF);
        busy       = (st == ST_PULSE) || (st == ST_VERIFY);
        sleep_req  = req_valid && (op == OP_SLEEP);
        is_job     = req_valid && ((op == OP_PROG) || (op == OP_ERASE) || (op == OP_LOCK));
        req_kind   = (op == OP_ERASE) ? JOB_ERASE : ((op == OP_LOCK) ? JOB_LOCK : JOB_PROG);
        acc_susp   = busy && req_valid && (op == OP_SUSP) && (job.kind != JOB_LOCK);
        vfy_end    = (st == ST_VERIFY) && tm_last && !acc_susp;
        vfy_pass   = vfy_end && !vfy_fail;
        vfy_giveup = vfy_end && vfy_fail && (tries == TW'(MAX_TRIES - 1));
    end

    wsm_blk_guard u_guard (
        .addr  (req_addr),
        .locks (lk),
        .wp    (wp),
        .pd    (pd_level),
        .blk   (g_blk),
        .ovr   (g_ovr),
        .deny  (g_deny)
    );

    wsm_step_timer #(
        .PULSE_CYC  (PULSE_CYC),
        .VERIFY_CYC (VERIFY_CYC)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (busy),
        .phase (st == ST_VERIFY),
        .last  (tm_last)
    );

    // Per-block lock bit update on a passing verify.
    for (genvar b = 0; b < NBLK; b++) begin : g_lock
        assign lk_nxt[b] =
            (!pd_off && vfy_pass && (job.blk == BLK_W'(b)) && (job.kind == JOB_LOCK))  ? 1'b0 :
            (!pd_off && vfy_pass && (job.blk == BLK_W'(b)) && (job.kind == JOB_ERASE)
                     && job.ovr) ? 1'b1 : lk[b];
    end

    always_ff @(posedge clk) begin
        if (rst) lk <= '1;
        else     lk <= lk_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst || pd_off) begin
            st         <= ST_IDLE;
            flags      <= '0;
            tries      <= '0;
            sleep_pend <= 1'b0;
            if (rst) job <= '{kind: JOB_PROG, blk: '0, ovr: 1'b0};
        end else begin
            // Clear first so that a same-edge error set below wins.
            if (req_valid && (op == OP_CLR)) begin
                flags.err_erase <= 1'b0;
                flags.err_prog  <= 1'b0;
                flags.ovp       <= 1'b0;
            end
            if (sleep_req && (busy || (st == ST_SUSP))) sleep_pend <= 1'b1;

            unique case (st)
                ST_IDLE: begin
                    if (is_job) begin
                        if (g_deny) begin
                            if (req_kind == JOB_ERASE) flags.err_erase <= 1'b1;
                            else                       flags.err_prog  <= 1'b1;
                        end else begin
                            st    <= ST_PULSE;
                            job   <= '{kind: req_kind, blk: g_blk, ovr: g_ovr};
                            tries <= '0;
                        end
                    end else if (sleep_req) begin
                        st <= ST_SLEEP;
                    end
                end
                ST_PULSE: begin
                    if (acc_susp) begin
                        st         <= ST_SUSP;
                        flags.susp <= 1'b1;
                    end else if (tm_last) begin
                        st <= ST_VERIFY;
                    end
                end
                ST_VERIFY: begin
                    if (acc_susp) begin
                        st         <= ST_SUSP;
                        flags.susp <= 1'b1;
                    end else if (vfy_pass) begin
                        if ((job.kind == JOB_PROG) && ovp_in) flags.ovp <= 1'b1;
                    end else if (vfy_giveup) begin
                        if (job.kind == JOB_ERASE) flags.err_erase <= 1'b1;
                        else                       flags.err_prog  <= 1'b1;
                    end else if (vfy_end) begin
                        tries <= tries + 1'b1;
                        st    <= ST_PULSE;
                    end
                end
                ST_SUSP: begin
                    if (req_valid && (op == OP_RESUME)) begin
                        st         <= ST_PULSE;
                        flags.susp <= 1'b0;
                    end
                end
                ST_SLEEP: begin
                    if (req_valid && (op == OP_WAKE)) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase

            if (vfy_pass || vfy_giveup) begin
                st         <= (sleep_pend || sleep_req) ? ST_SLEEP : ST_IDLE;
                sleep_pend <= 1'b0;
            end
        end
    end

    always_comb begin
        status    = pack_status(busy, flags);
        ry_by     = ~busy;
        asleep    = (st == ST_SLEEP);
        lock_bits = lk;
    end
endmodule

// File: rtl/flash_wsm_chk.sv
module flash_wsm_chk
    import flash_wsm_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [2:0]      req_op,
    input logic [1:0]      pd_level,
    input logic [7:0]      status,
    input logic            ry_by,
    input logic            asleep,
    input logic [NBLK-1:0] lock_bits
);
    AST_READY_PIN: assert property (@(posedge clk) disable iff (rst)
        ry_by == status[7]);                                           // R2

    AST_BUSY_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $fell(ry_by) |-> $past(req_valid));                            // R2

    AST_ERASE_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status[5] && !(req_valid && req_op == 3'd6) && pd_level != 2'b00)
        |=> status[5]);                                                // R5

    AST_PROG_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status[4] && !(req_valid && req_op == 3'd6) && pd_level != 2'b00)
        |=> status[4]);                                                // R5

    AST_SUSP_READY: assert property (@(posedge clk) disable iff (rst)
        status[6] |-> status[7]);                                      // R9

    AST_SLEEP_READY: assert property (@(posedge clk) disable iff (rst)
        asleep |-> ry_by);                                             // R10

    AST_PD_IDLE_STATUS: assert property (@(posedge clk) disable iff (rst)
        (pd_level == 2'b00) |=> (status == 8'h80));                    // R11

    AST_LOCK_AT_JOB_END: assert property (@(posedge clk) disable iff (rst)
        !$stable(lock_bits) |-> !$past(ry_by));                        // R8
endmodule

bind flash_wsm flash_wsm_chk u_chk (.*);

// File: tb/flash_wsm_bench.sv
`timescale 1ns/1ps
module flash_wsm_bench;
    localparam int P   = 4;
    localparam int V   = 2;
    localparam int MT  = 3;
    localparam int RND = P + V;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  req_op;
    logic [18:0] req_addr;
    logic        wp;
    logic [1:0]  pd_level;
    logic        vfy_fail;
    logic        ovp_in;
    logic [7:0]  status;
    logic        ry_by;
    logic        asleep;
    logic [18:0] lock_bits;

    int n_chk  = 0;
    int n_fail = 0;
    logic [18:0] exp_lock;

    always #4 clk = ~clk;

    flash_wsm #(.PULSE_CYC(P), .VERIFY_CYC(V), .MAX_TRIES(MT)) u_flash_wsm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .wp(wp), .pd_level(pd_level), .vfy_fail(vfy_fail),
        .ovp_in(ovp_in), .status(status), .ry_by(ry_by), .asleep(asleep),
        .lock_bits(lock_bits)
    );

    function automatic int blk_model(input logic [18:0] a);
        if (a >= 19'h08000) return int'(a) / 32768 + 3;
        if (a >= 19'h04000) return 3;
        if (a >= 19'h03000) return 2;
        if (a >= 19'h02000) return 1;
        return 0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a negedge; the request is taken on the following posedge.
    task automatic issue(input logic [2:0] op, input logic [18:0] a);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int ra;
        ra = $urandom(32'd2024);
        rst = 1'b1; req_valid = 1'b0; req_op = '0; req_addr = '0;
        wp = 1'b0; pd_level = 2'b01; vfy_fail = 1'b0; ovp_in = 1'b0;
        exp_lock = '1;
        wait_n(3);
        rst = 1'b0;

        // R1 reset state
        chk("R1 status", status, 8'h80);
        chk("R1 ry_by", ry_by, 1);
        chk("R1 locks", lock_bits, 19'h7FFFF);
        chk("R1 asleep", asleep, 0);

        // R2 single-round program timing
        issue(3'd1, 19'h00100);
        chk("R2 busy flag", status, 8'h00);
        chk("R2 ry_by low", ry_by, 0);
        wait_n(RND - 1);
        chk("R2 still busy", ry_by, 0);
        wait_n(1);
        chk("R2 ready", status, 8'h80);

        // R3 one failing round then pass, with over-program flag
        vfy_fail = 1'b1; ovp_in = 1'b1;
        issue(3'd1, 19'h00200);
        wait_n(RND);
        vfy_fail = 1'b0;
        wait_n(RND - 1);
        chk("R3 retry busy", ry_by, 0);
        wait_n(1);
        chk("R3 retry done ovp", status, 8'h88);
        ovp_in = 1'b0;
        issue(3'd6, 19'h0);
        chk("R5 clear ovp", status, 8'h80);

        // R4 erase retries exhausted
        vfy_fail = 1'b1;
        issue(3'd2, 19'h10000);
        wait_n(MT * RND - 1);
        chk("R4 busy before limit", ry_by, 0);
        wait_n(1);
        chk("R4 erase error", status, 8'hA0);
        vfy_fail = 1'b0;
        issue(3'd1, 19'h00300);
        wait_n(RND);
        chk("R5 erase err sticky", status, 8'hA0);
        issue(3'd6, 19'h0);
        chk("R5 cleared", status, 8'h80);

        // R5 clear on the same edge as the error set
        vfy_fail = 1'b1;
        issue(3'd1, 19'h00400);
        wait_n(MT * RND - 1);
        issue(3'd6, 19'h0);
        chk("R5 set wins over clear", status, 8'h90);
        vfy_fail = 1'b0;
        issue(3'd6, 19'h0);
        chk("R5 cleared again", status, 8'h80);

        // R8 / R12 lock jobs at map boundaries
        begin
            logic [18:0] la [7];
            la[0] = 19'h01FFF; la[1] = 19'h02000; la[2] = 19'h03ABC; la[3] = 19'h04000;
            la[4] = 19'h07FFF; la[5] = 19'h08000; la[6] = 19'h7FFFF;
            for (int i = 0; i < 7; i++) begin
                issue(3'd3, la[i]);
                wait_n(RND);
                exp_lock[blk_model(la[i])] = 1'b0;
                chk("R8 R12 lock bit map", lock_bits, exp_lock);
            end
        end

        // R6 rejection on locked blocks
        issue(3'd1, 19'h00010);
        chk("R6 program rejected ready", ry_by, 1);
        chk("R6 program error", status, 8'h90);
        issue(3'd2, 19'h08100);
        chk("R6 erase error", status, 8'hB0);
        chk("R6 locks unchanged", lock_bits, exp_lock);
        issue(3'd6, 19'h0);

        // R7 override by protect pin and by high-voltage level
        wp = 1'b1;
        issue(3'd2, 19'h08000);
        chk("R7 erase proceeds", ry_by, 0);
        wait_n(RND);
        exp_lock[4] = 1'b1;
        chk("R7 erase relocks to 1", lock_bits, exp_lock);
        wp = 1'b0; pd_level = 2'b10;
        issue(3'd2, 19'h7C000);
        wait_n(RND);
        exp_lock[18] = 1'b1;
        chk("R7 hv erase", lock_bits, exp_lock);
        issue(3'd1, 19'h00020);
        chk("R7 hv program runs", ry_by, 0);
        wait_n(RND);
        chk("R7 hv program ok", status, 8'h80);
        pd_level = 2'b01;

        // R9 suspend / resume
        issue(3'd1, 19'h20000);
        wait_n(2);
        issue(3'd4, 19'h0);
        chk("R9 suspended", status, 8'hC0);
        wait_n(5);
        chk("R9 stays suspended", status, 8'hC0);
        issue(3'd5, 19'h0);
        chk("R9 resumed busy", status, 8'h00);
        wait_n(RND - 1);
        chk("R9 resumed round", ry_by, 0);
        wait_n(1);
        chk("R9 done", status, 8'h80);

        // R10 sleep
        issue(3'd7, 19'h0);
        chk("R10 idle sleep", asleep, 1);
        issue(3'd1, 19'h30000);
        chk("R10 job ignored asleep", ry_by, 1);
        issue(3'd0, 19'h0);
        chk("R10 wake", asleep, 0);
        issue(3'd1, 19'h30000);
        wait_n(1);
        issue(3'd7, 19'h0);
        wait_n(RND - 3);
        chk("R10 sleep deferred", asleep, 0);
        wait_n(1);
        chk("R10 sleep at end", {asleep, ry_by}, 2'b11);
        issue(3'd0, 19'h0);

        // R11 power-down abort
        issue(3'd1, 19'h02000);
        chk("R11 pre error", status, 8'h90);
        issue(3'd1, 19'h40000);
        wait_n(2);
        pd_level = 2'b00;
        wait_n(1);
        chk("R11 status reset", status, 8'h80);
        issue(3'd1, 19'h40000);
        chk("R11 ignored", ry_by, 1);
        chk("R11 locks kept", lock_bits, exp_lock);
        pd_level = 2'b01;
        wait_n(1);

        // R6 / R12 random programs against the lock model
        for (int i = 0; i < 40; i++) begin
            logic [18:0] a;
            logic        deny;
            a    = 19'($urandom);
            wp   = 1'($urandom);
            deny = !wp && !exp_lock[blk_model(a)];
            issue(3'd1, a);
            chk("R6 R12 random accept", ry_by, deny);
            if (deny) begin
                chk("R6 random error bit", status[4], 1);
                issue(3'd6, 19'h0);
            end else begin
                wait_n(RND);
                chk("R2 random done", status, 8'h80);
            end
        end

        summary();
        $finish;
    end
endmodule